// File: doc/BRIEF.md
# Clocked Serial Receive Channel

This block receives serial data that arrives with its own external bit clock. Both serial lines pass through synchronisers into the system clock domain. On each rising edge of the synchronised bit clock, one data bit is captured, least significant bit first. When eight bits have arrived, the byte moves into a holding register and a "full" flag is raised. A small register port lets a host do three things: enable the receiver, read the flags, and read the byte. Reading the byte clears the full flag with no extra write.

If a second byte completes before the host has read the first one, the held byte is kept, the new byte is thrown away, and an overrun flag is raised. While the overrun flag is set the receiver is frozen. It accepts nothing until the host writes a 0 to that flag. Two level interrupt outputs follow the flags.

Top module: `clksync_rx`

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are 0. Register map: offset 0 is control (bit 0 = receive enable, bit 1 = receive-interrupt enable). Offset 1 is status (bit 0 = full, bit 1 = overrun). Offset 2 is the received byte. Offset 3 reads 0.
- R2: With receive enable set, the line is sampled on each synchronised rising edge of the bit clock. The first bit becomes bit 0 and the eighth becomes bit 7. After the eighth bit the byte appears at offset 2 and the full flag becomes 1.
- R3: A read at offset 2 returns the byte and clears the full flag. Reads at offsets 0 and 1 change nothing.
- R4: If a byte completes while the full flag is 1, the overrun flag becomes 1 and offset 2 keeps the earlier byte.
- R5: While the overrun flag is 1, serial traffic is ignored. After the flag is cleared, reception starts again at bit 0 of a fresh byte.
- R6: Writing offset 1 with bit 1 = 0 clears the overrun flag. Writing bit 1 = 1 leaves it unchanged. The full flag cannot be written.
- R7: Clearing receive enable discards any partly received byte and ignores further serial traffic. The full and overrun flags keep their values.
- R8: The receive-interrupt output equals full AND receive-interrupt enable. The error-interrupt output equals the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | External serial bit clock |
| sd_i | input | 1 | Serial data line |
| addr_i | input | 2 | Register offset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effect on offset 2) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_err_o | output | 1 | Overrun interrupt |

## Verification
The bench sends all 256 byte values and checks each against the value it sent. A design that takes bits MSB first, or that loses the first or last bit, fails this sweep.

It forces an overrun, then sends a third byte while the flag is set. A receiver that keeps shifting, or that overwrites the held byte, shows the wrong value when offset 2 is read later. The same test catches a bit counter that is not reset when the flag clears, because the next byte then arrives misaligned.

It writes a 1 to the overrun flag and checks that the flag stays set. This catches a design that toggles the flag or clears it on any write.

It disables the receiver partway through a byte and then checks that the next byte is aligned. It also checks that the flags survive while the receiver is disabled.

// File: rtl/crx_pkg.sv
package crx_pkg;
    localparam int CRX_CTRL_OFS = 0;
    localparam int CRX_STAT_OFS = 1;
    localparam int CRX_DATA_OFS = 2;
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_IE_BIT  = 1;
    localparam int STAT_FULL_BIT = 0;
    localparam int STAT_OVR_BIT  = 1;
endpackage

// File: rtl/crx_sync.sv
module crx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sd_i,
    output logic rise_o,
    output logic sd_o
);
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] sd_q;
    logic              sck_prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_q[0] <= 1'b0;
                    sd_q[0]  <= 1'b0;
                end else begin
                    sck_q[0] <= sck_i;
                    sd_q[0]  <= sd_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_q[i] <= 1'b0;
                    sd_q[i]  <= 1'b0;
                end else begin
                    sck_q[i] <= sck_q[i-1];
                    sd_q[i]  <= sd_q[i-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_q[STAGES-1];
    end

    assign rise_o = sck_q[STAGES-1] & ~sck_prev_q;
    assign sd_o   = sd_q[STAGES-1];
endmodule

// File: rtl/crx_shift.sv
module crx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              rise_i,
    input  logic              sd_i,
    output logic              done_o,
    output logic [DATA_W-1:0] byte_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        byte_o = {sd_i, st_q.sh[DATA_W-1:1]};
        if (!run_i) begin
            st_d = '0;
        end else if (rise_i) begin
            st_d.sh = byte_o;
            if (st_q.cnt == LAST) begin
                done_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r7_idle_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run_i) |-> !done_o);
endmodule

// File: rtl/crx_regs.sv
module crx_regs
    import crx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              run_o,
    output logic              irq_rx_o,
    output logic              irq_err_o
);
    typedef struct packed {
        logic              en;
        logic              ie;
        logic              full;
        logic              ovr;
        logic [DATA_W-1:0] data;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    sel_ctrl, sel_stat, sel_data, data_read, full_eff;

    always_comb begin
        sel_ctrl  = addr_i == ADDR_W'(CRX_CTRL_OFS);
        sel_stat  = addr_i == ADDR_W'(CRX_STAT_OFS);
        sel_data  = addr_i == ADDR_W'(CRX_DATA_OFS);
        data_read = rd_en_i && sel_data;
        full_eff  = st_q.full && !data_read;

        st_d      = st_q;
        st_d.full = full_eff;
        if (wr_en_i && sel_ctrl) begin
            st_d.en = wdata_i[CTRL_EN_BIT];
            st_d.ie = wdata_i[CTRL_IE_BIT];
        end
        if (wr_en_i && sel_stat && !wdata_i[STAT_OVR_BIT]) begin
            st_d.ovr = 1'b0;
        end
        if (done_i) begin
            if (full_eff) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.data = byte_i;
                st_d.full = 1'b1;
            end
        end

        rdata_o = '0;
        if (sel_ctrl) begin
            rdata_o[CTRL_EN_BIT] = st_q.en;
            rdata_o[CTRL_IE_BIT] = st_q.ie;
        end else if (sel_stat) begin
            rdata_o[STAT_FULL_BIT] = st_q.full;
            rdata_o[STAT_OVR_BIT]  = st_q.ovr;
        end else if (sel_data) begin
            rdata_o = st_q.data;
        end

        run_o     = st_q.en && !st_q.ovr;
        irq_rx_o  = st_q.full && st_q.ie;
        irq_err_o = st_q.ovr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r2_frame_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !st_q.full) |=> (st_q.full && st_q.data == $past(byte_i)));
    a_r3_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && sel_data && !done_i) |=> !st_q.full);
    a_r4_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && st_q.full && !(rd_en_i && sel_data)) |=> (st_q.ovr && $stable(st_q.data)));
    a_r5_frozen_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |-> !done_i);
    a_r6_one_write_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && wr_en_i && sel_stat && wdata_i[STAT_OVR_BIT]) |=> st_q.ovr);
endmodule

// File: rtl/clksync_rx.sv
module clksync_rx #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              sd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_rx_o,
    output logic              irq_err_o
);
    logic              rise, sd_s, run, done;
    logic [DATA_W-1:0] rx_byte;

    crx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .sd_i(sd_i),
        .rise_o(rise), .sd_o(sd_s)
    );

    crx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .run_i(run), .rise_i(rise), .sd_i(sd_s),
        .done_o(done), .byte_o(rx_byte)
    );

    crx_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .wdata_i(wdata_i), .done_i(done), .byte_i(rx_byte),
        .rdata_o(rdata_o), .run_o(run), .irq_rx_o(irq_rx_o), .irq_err_o(irq_err_o)
    );

    a_r8_err_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_err_o) |-> $past(done));
endmodule

// File: tb/tb_clksync_rx.sv
module tb_clksync_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, sd = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_rx, irq_err;
    int         checks = 0, errors = 0;
    logic       finished = 1'b0;

    always #2.5 clk = ~clk;

    clksync_rx dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sd_i(sd), .addr_i(addr),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata),
        .irq_rx_o(irq_rx), .irq_err_o(irq_err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sd = v[i];
            repeat (2) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); check("R1 reg", v, 8'h00);
        end
        check("R1 irq", {6'b0, irq_rx, irq_err}, 8'h00);

        // R7 disabled receiver ignores traffic
        send(8'h5A, 8);
        rd(2'd1, v); check("R7 disabled", v, 8'h00);

        wr(2'd0, 8'h01);
        rd(2'd0, v); check("R1 ctrl readback", v, 8'h01);

        // R2/R3 sweep of all byte values
        for (int b = 0; b < 256; b++) begin
            send(8'(b), 8);
            rd(2'd1, v); check("R2 full", v, 8'h01);
            rd(2'd2, v); check("R2 data", v, 8'(b));
            rd(2'd1, v); check("R3 cleared", v, 8'h00);
        end

        // R4 overrun
        send(8'hA5, 8);
        rd(2'd1, v); check("R3 status read no effect", v, 8'h01);
        send(8'h3C, 8);
        rd(2'd1, v); check("R4 status", v, 8'h03);
        check("R8 err irq", {7'b0, irq_err}, 8'h01);
        // R5 ignored while frozen
        send(8'hFF, 8);
        send(8'h0F, 3);
        // R6 writing 1 has no effect
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check("R6 one ignored", v, 8'h03);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R6 cleared", v, 8'h01);
        check("R8 err irq low", {7'b0, irq_err}, 8'h00);
        rd(2'd2, v); check("R4 kept", v, 8'hA5);
        rd(2'd1, v); check("R5 nothing loaded", v, 8'h00);
        send(8'hC3, 8);
        rd(2'd2, v); check("R5 aligned", v, 8'hC3);

        // R7 partial frame discarded
        send(8'hFF, 4);
        wr(2'd0, 8'h00);
        send(8'hFF, 8);
        rd(2'd1, v); check("R7 no frame", v, 8'h00);
        wr(2'd0, 8'h01);
        send(8'h96, 8);
        rd(2'd1, v); check("R7 full", v, 8'h01);
        // R8 interrupt gating
        check("R8 rx irq masked", {7'b0, irq_rx}, 8'h00);
        wr(2'd0, 8'h03);
        check("R8 rx irq", {7'b0, irq_rx}, 8'h01);
        wr(2'd0, 8'h02);
        rd(2'd1, v); check("R7 flags kept", v, 8'h01);
        rd(2'd2, v); check("R7 data", v, 8'h96);
        check("R8 rx irq clear", {7'b0, irq_rx}, 8'h00);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule